// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, and moves words between them in either direction. Each direction has its own storage register with its own clock: the A-to-B register samples the A-side input and the B-to-A register samples the B-side input. On every rising edge of its clock, a register takes in the word present on its input side. This happens whatever the enable and direction inputs are doing, so data can be parked while both buses are isolated.

Each side has a source select. With the select low, a bus shows the live word from the opposite bus through a purely combinational path. With the select high, it shows the word held in the register for its direction. One active-low enable and one direction input decide which bus is driven, if any. The two buses are never driven together. For synthesis, each bidirectional bus is split into an input vector, a data output vector and an output-enable vector. The enable vector copies one bus-level enable to every bit. A surrounding pad wrapper can combine these three vectors into tri-state pins.

The words move as continuous bus levels, not as discrete transfers, so there is no valid/ready handshake and no back-pressure. An asynchronous active-low reset clears both registers to zero.

Top module: `xcvr_regbus`

## Requirements
- R1: On each rising edge of `clk_ab` while out of reset, the A-to-B register loads `a_in`. This happens for every value of `oe_n` and `dir`, including isolation.
- R2: On each rising edge of `clk_ba` while out of reset, the B-to-A register loads `b_in`. This happens for every value of `oe_n` and `dir`, including isolation.
- R3: Asserting `rst_n` low clears both registers to zero at once. Without a rising edge on its own clock, a register keeps its word while the bus inputs change.
- R4: While `oe_n` is 1, `a_oe` and `b_oe` are both all zeros, so neither bus is driven.
- R5: While `oe_n` is 0 and `dir` is 1, `b_oe` is all ones and `a_oe` is all zeros.
- R6: While `oe_n` is 0 and `dir` is 0, `a_oe` is all ones and `b_oe` is all zeros.
- R7: With `sel_ab` at 0, `b_out` equals `a_in` in the same cycle. With `sel_ab` at 1, `b_out` equals the A-to-B register. This holds whatever the enable state is.
- R8: With `sel_ba` at 0, `a_out` equals `b_in` in the same cycle. With `sel_ba` at 1, `a_out` equals the B-to-A register. This holds whatever the enable state is.
- R9: `a_oe` and `b_oe` never both have a bit set. Each of the two vectors is always either all zeros or all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| oe_n | input | 1 | Active-low bus drive enable |
| dir | input | 1 | 1 drives bus B, 0 drives bus A |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored word |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored word |
| a_in | input | WIDTH | Word received from bus A |
| a_out | output | WIDTH | Word offered to bus A |
| a_oe | output | WIDTH | Per-bit drive enable for bus A |
| b_in | input | WIDTH | Word received from bus B |
| b_out | output | WIDTH | Word offered to bus B |
| b_oe | output | WIDTH | Per-bit drive enable for bus B |

## Verification
Directed sequences come first.
- Loading both registers during isolation, then exposing them through the stored selects, shows that capture does not depend on the drive enables.
- Holding both clocks still while the bus inputs toggle tells a register that holds its word apart from one that follows its input.
- Asserting reset in the middle of a run, with words already stored, confirms the clear.

A long run of random words then mixes random enable, direction, select and clock-strobe settings. This separates the live paths from the stored paths and the A side from the B side. It also covers every row of the drive table, with the two clocks strobed both independently and together.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_e;

  function automatic drive_e decode_drive(input logic oe_n, input logic dir);
    if (oe_n)     return DRV_NONE;
    else if (dir) return DRV_B;
    else          return DRV_A;
  endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/xcvr_srcsel.sv
module xcvr_srcsel #(
  parameter int WIDTH = 8
) (
  input  logic             use_stored,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] word
);

  always_comb begin
    word = use_stored ? stored : live;
  end

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int WIDTH = 8
) (
  input  logic             oe_n,
  input  logic             dir,
  output logic [WIDTH-1:0] a_oe,
  output logic [WIDTH-1:0] b_oe
);
  import xcvr_pkg::*;

  drive_e mode;
  logic   en_a;
  logic   en_b;

  always_comb begin
    mode = decode_drive(oe_n, dir);
    en_a = (mode == DRV_A);
    en_b = (mode == DRV_B);
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_fan
    assign a_oe[i] = en_a;
    assign b_oe[i] = en_b;
  end

endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus #(
  parameter int WIDTH = 8
) (
  input  logic             rst_n,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);

  logic [WIDTH-1:0] held_ab;
  logic [WIDTH-1:0] held_ba;

  // R1: A-side word parked for bus B
  xcvr_store #(.WIDTH(WIDTH)) u_store_ab (
    .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(held_ab)
  );

  // R2: B-side word parked for bus A
  xcvr_store #(.WIDTH(WIDTH)) u_store_ba (
    .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(held_ba)
  );

  // R7
  xcvr_srcsel #(.WIDTH(WIDTH)) u_sel_b (
    .use_stored(sel_ab), .live(a_in), .stored(held_ab), .word(b_out)
  );

  // R8
  xcvr_srcsel #(.WIDTH(WIDTH)) u_sel_a (
    .use_stored(sel_ba), .live(b_in), .stored(held_ba), .word(a_out)
  );

  // R4 R5 R6 R9
  xcvr_drive #(.WIDTH(WIDTH)) u_drive (
    .oe_n(oe_n), .dir(dir), .a_oe(a_oe), .b_oe(b_oe)
  );

endmodule

// File: rtl/xcvr_regbus_chk.sv
module xcvr_regbus_chk #(
  parameter int WIDTH = 8
) (
  input logic             rst_n,
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             oe_n,
  input logic             dir,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic [WIDTH-1:0] a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic [WIDTH-1:0] b_oe
);

  assert_store_ab_R1: assert property (@(posedge clk_ab) disable iff (!rst_n)
    1'b1 |=> (!sel_ab || (b_out == $past(a_in))));

  assert_store_ba_R2: assert property (@(posedge clk_ba) disable iff (!rst_n)
    1'b1 |=> (!sel_ba || (a_out == $past(b_in))));

  assert_isolate_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
    oe_n |-> (a_oe == '0 && b_oe == '0));

  assert_drive_b_R5: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_n && dir) |-> (b_oe == '1 && a_oe == '0));

  assert_drive_a_R6: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!oe_n && !dir) |-> (a_oe == '1 && b_oe == '0));

  assert_live_b_R7: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !sel_ab |-> (b_out == a_in));

  assert_live_a_R8: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !sel_ba |-> (a_out == b_in));

  assert_one_driver_R9: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !((|a_oe) && (|b_oe)) && (a_oe == '0 || a_oe == '1) && (b_oe == '0 || b_oe == '1));

endmodule

bind xcvr_regbus xcvr_regbus_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_xcvr_regbus.sv
`timescale 1ns/1ps
module sim_xcvr_regbus;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_ab = 1'b0, en_ba = 1'b0;
  logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic clk_ab, clk_ba;

  int vectors = 0;
  int errors  = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  always #4 clk = ~clk;
  assign clk_ab = clk & en_ab;
  assign clk_ba = clk & en_ba;

  xcvr_regbus #(.WIDTH(W)) u0 (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // behavioural reference of the two stored words
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ab <= '0;
      m_ba <= '0;
    end else begin
      if (en_ab) m_ab <= a_in;
      if (en_ba) m_ba <= b_in;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [W-1:0] ea, eb;
    ea = '0; eb = '0;
    if (!oe_n && !dir) ea = '1;
    if (!oe_n &&  dir) eb = '1;
    check(oe_n ? "R4" : (dir ? "R5" : "R6"), "a_oe", a_oe, ea);
    check(oe_n ? "R4" : (dir ? "R5" : "R6"), "b_oe", b_oe, eb);
    check("R9", "overlap", a_oe & b_oe, '0);
    check(sel_ab ? "R1/R7" : "R7", "b_out", b_out, sel_ab ? m_ab : a_in);
    check(sel_ba ? "R2/R8" : "R8", "a_out", a_out, sel_ba ? m_ba : b_in);
  endtask

  task automatic step(input logic eab, input logic eba);
    @(negedge clk);
    en_ab = eab; en_ba = eba;
    @(posedge clk);
    @(negedge clk);
    en_ab = 1'b0; en_ba = 1'b0;
    #1;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    sel_ab = 1'b1; sel_ba = 1'b1;
    a_in = 8'h5A; b_in = 8'hC3;
    repeat (3) @(negedge clk);
    #1;
    check("R3", "reset b_out", b_out, 8'h00);
    check("R3", "reset a_out", a_out, 8'h00);
    check("R4", "reset a_oe", a_oe, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2: load while isolated, then expose stored words
    oe_n = 1'b1; a_in = 8'h3C; b_in = 8'hA5;
    step(1'b1, 1'b1);
    a_in = 8'h11; b_in = 8'h22;
    oe_n = 1'b0; dir = 1'b1; #1;
    check("R1", "stored A under isolation", b_out, 8'h3C);
    check("R5", "b_oe", b_oe, 8'hFF);
    dir = 1'b0; #1;
    check("R2", "stored B under isolation", a_out, 8'hA5);
    check("R6", "a_oe", a_oe, 8'hFF);

    // R3 hold: no clock edges, inputs toggle
    for (int i = 0; i < 4; i++) begin
      a_in = 8'(i * 37 + 1); b_in = 8'(~(i * 53));
      step(1'b0, 1'b0);
      check("R3", "hold ab", b_out, 8'h3C);
      check("R3", "hold ba", a_out, 8'hA5);
    end

    // R1 vs R2 independence: only A-to-B strobed
    a_in = 8'h77; b_in = 8'h99;
    step(1'b1, 1'b0);
    check("R1", "ab only", b_out, 8'h77);
    check("R2", "ba untouched", a_out, 8'hA5);

    // R7 R8 live paths
    sel_ab = 1'b0; sel_ba = 1'b0; a_in = 8'hE1; b_in = 8'h1E; #1;
    check("R7", "live b_out", b_out, 8'hE1);
    check("R8", "live a_out", a_out, 8'h1E);

    // random sweep against the reference
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      en_ab = 1'($urandom); en_ba = 1'($urandom);
      oe_n = 1'($urandom); dir = 1'($urandom);
      sel_ab = 1'($urandom); sel_ba = 1'($urandom);
      a_in = W'($urandom); b_in = W'($urandom);
      #1;
      compare_all();
    end

    // R3 asynchronous clear mid-run
    @(negedge clk);
    en_ab = 1'b0; en_ba = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    rst_n = 1'b0; #1;
    check("R3", "clear ab", b_out, 8'h00);
    check("R3", "clear ba", a_out, 8'h00);
    @(negedge clk); rst_n = 1'b1; #1;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule